// File: doc/BRIEF.md
# Debug Peripheral Freeze Controller

This block decides, cycle by cycle, which on-chip peripherals are held still while software or a debugger inspects the system. Eleven freeze lines leave the block, one per target. Software raises a line with a write-one-to-set register and drops it with a paired write-one-to-clear register. A debug halt of the main CPU or of an auxiliary CPU can also freeze every target. Each of these halt sources has its own enable bit.

The same debug register routes a halt from one CPU to the other in either direction. A sensitivity bit selects whether the routed request follows the source halt level or fires once on its rising edge. Each direction has a two-state machine. `HALT_IDLE` means the source halt was low on the last clock and `HALT_HELD` means it was high. The transition IDLE→HELD is taken when the source rises and HELD→IDLE when it falls. A pulse request is produced only while the machine is in `HALT_IDLE` and the source is already high.

The block also holds a core-stall bit that keeps the main core waiting, and two general-purpose flag bits. All access goes through a plain 32-bit register port: a write strobe, an address and write data, with read data returned combinationally for the current address.

Top module: `dbg_freeze_ctrl`

## Requirements
- R1: After reset the freeze state is 0 and all routing, stall and flag bits are 0. The main-CPU freeze enable (debug register bit 0) is 1, so a read of offset 0x8 with both halts low returns 0x00000001. All outputs are 0.
- R2: A write to offset 0x0 sets each freeze-state bit whose data bit is 1, and written zeros leave bits unchanged. A read of offset 0x0 or 0x4 returns the freeze state in bits 10:0, with zeros above.
- R3: A write to offset 0x4 clears each freeze-state bit whose data bit is 1, and written zeros leave bits unchanged.
- R4: Freeze output bit i follows freeze-state bit i when no halt applies. The bit order is: 0 wake-up timer, 1 timer, 2 reserved, 3 system watchdog, 4 USB, 5 DMA, 6 timer 2, 7 PWM LED, 8 timer 3, 9 timer 4, 10 auxiliary-CPU watchdog.
- R5: The software freeze of the system watchdog (bit 3) takes effect only while `nmi_rst_mode` is 0.
- R6: While `sys_dbg_halt` is 1 and debug bit 0 is 1, all eleven freeze outputs are 1. With debug bit 0 at 0, targets other than the system watchdog follow only the software freeze state.
- R7: The system-watchdog freeze output is 1 whenever `sys_dbg_halt` is 1, whatever the state of debug bit 0 or `nmi_rst_mode`.
- R8: While `aux_dbg_halt` is 1 and debug bit 1 is 1, every freeze output is 1. The exception is the system-watchdog output, which this source drives only while `nmi_rst_mode` is 0.
- R9: Debug bit 2 enables the main→auxiliary halt request and bit 3 enables the auxiliary→main request. With debug bit 7 = 0 (level mode), an enabled request equals its source halt in the same cycle, and a disabled request is 0.
- R10: With debug bit 7 = 1 (pulse mode), an enabled request is 1 only in a cycle where the source halt is 1 and was 0 at the previous clock. The request lasts one cycle even if the source stays high.
- R11: Debug bits 4 and 5 read the current `sys_dbg_halt` and `aux_dbg_halt`. Writes to those bits have no effect.
- R12: Debug bit 6 drives `core_stall` from the clock after the write. Writing it to 0 releases the stall.
- R13: Bit 0 of offset 0xC drives `cal_flag` and bit 0 of offset 0x10 drives `bridge_skip`. Both are read back at bit 0. Other offsets read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| sys_dbg_halt | input | 1 | Main CPU halted in debug |
| aux_dbg_halt | input | 1 | Auxiliary CPU halted in debug |
| nmi_rst_mode | input | 1 | Watchdog in NMI-reset mode; blocks its software freeze |
| frz | output | 11 | Per-target freeze lines |
| halt_req_aux | output | 1 | Halt request toward the auxiliary CPU |
| halt_req_main | output | 1 | Halt request toward the main CPU |
| core_stall | output | 1 | Holds the main core waiting |
| cal_flag | output | 1 | General-purpose status flag |
| bridge_skip | output | 1 | General-purpose control flag |

## Verification
A corrupted freeze-state bit shows on its `frz` line and on the read of offset 0x0 in the very next cycle. A reference model compared on every clock therefore catches it at once. A halt machine stuck in the wrong state shows only in pulse mode: it gives a missing or repeated request on the first source edge. The bench therefore drives held, released and re-raised halts under both sensitivities. Wrong gating between halts, enables and the NMI-mode input shows combinationally on `frz` in the same cycle as the input change.

// File: rtl/dfc_pkg.sv
package dfc_pkg;
    parameter int unsigned DATA_W = 32;
    parameter int unsigned ADDR_W = 5;
    parameter int unsigned N_FRZ  = 11;

    localparam int unsigned WDOG_BIT = 3;

    localparam logic [ADDR_W-1:0] OFF_SET  = ADDR_W'(8'h00);
    localparam logic [ADDR_W-1:0] OFF_CLR  = ADDR_W'(8'h04);
    localparam logic [ADDR_W-1:0] OFF_DBG  = ADDR_W'(8'h08);
    localparam logic [ADDR_W-1:0] OFF_STAT = ADDR_W'(8'h0C);
    localparam logic [ADDR_W-1:0] OFF_CTRL = ADDR_W'(8'h10);

    localparam int unsigned DB_SYS_FEN = 0;
    localparam int unsigned DB_AUX_FEN = 1;
    localparam int unsigned DB_R_M2A   = 2;
    localparam int unsigned DB_R_A2M   = 3;
    localparam int unsigned DB_SYS_H   = 4;
    localparam int unsigned DB_AUX_H   = 5;
    localparam int unsigned DB_STALL   = 6;
    localparam int unsigned DB_PULSE   = 7;

    typedef enum logic {
        HALT_IDLE = 1'b0,
        HALT_HELD = 1'b1
    } halt_st_e;
endpackage

// File: rtl/dfc_regs.sv
module dfc_regs
    import dfc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              sys_halt,
    input  logic              aux_halt,
    output logic [N_FRZ-1:0]  sw_frz,
    output logic              sys_fen,
    output logic              aux_fen,
    output logic              route_m2a,
    output logic              route_a2m,
    output logic              stall,
    output logic              pulse_mode,
    output logic              cal,
    output logic              byp,
    output logic [DATA_W-1:0] rdata
);
    logic [N_FRZ-1:0] frz_q;
    logic sys_fen_q, aux_fen_q, m2a_q, a2m_q, stall_q, pulse_q, cal_q, byp_q;
    logic unused_wdata;
    assign unused_wdata = ^wdata[DATA_W-1:N_FRZ];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frz_q     <= '0;
            sys_fen_q <= 1'b1;
            aux_fen_q <= 1'b0;
            m2a_q     <= 1'b0;
            a2m_q     <= 1'b0;
            stall_q   <= 1'b0;
            pulse_q   <= 1'b0;
            cal_q     <= 1'b0;
            byp_q     <= 1'b0;
        end else if (wr_en) begin
            case (addr)
                OFF_SET:  frz_q <= frz_q | wdata[N_FRZ-1:0];
                OFF_CLR:  frz_q <= frz_q & ~wdata[N_FRZ-1:0];
                OFF_DBG: begin
                    sys_fen_q <= wdata[DB_SYS_FEN];
                    aux_fen_q <= wdata[DB_AUX_FEN];
                    m2a_q     <= wdata[DB_R_M2A];
                    a2m_q     <= wdata[DB_R_A2M];
                    stall_q   <= wdata[DB_STALL];
                    pulse_q   <= wdata[DB_PULSE];
                end
                OFF_STAT: cal_q <= wdata[0];
                OFF_CTRL: byp_q <= wdata[0];
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            OFF_SET, OFF_CLR: rdata[N_FRZ-1:0] = frz_q;
            OFF_DBG: begin
                rdata[DB_SYS_FEN] = sys_fen_q;
                rdata[DB_AUX_FEN] = aux_fen_q;
                rdata[DB_R_M2A]   = m2a_q;
                rdata[DB_R_A2M]   = a2m_q;
                rdata[DB_SYS_H]   = sys_halt;
                rdata[DB_AUX_H]   = aux_halt;
                rdata[DB_STALL]   = stall_q;
                rdata[DB_PULSE]   = pulse_q;
            end
            OFF_STAT: rdata[0] = cal_q;
            OFF_CTRL: rdata[0] = byp_q;
            default: ;
        endcase
    end

    assign sw_frz     = frz_q;
    assign sys_fen    = sys_fen_q;
    assign aux_fen    = aux_fen_q;
    assign route_m2a  = m2a_q;
    assign route_a2m  = a2m_q;
    assign stall      = stall_q;
    assign pulse_mode = pulse_q;
    assign cal        = cal_q;
    assign byp        = byp_q;

    // R2
    set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFF_SET) |=>
        ((frz_q & $past(wdata[N_FRZ-1:0])) == $past(wdata[N_FRZ-1:0])));
    // R3
    clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFF_CLR) |=> ((frz_q & $past(wdata[N_FRZ-1:0])) == '0));
    // R2
    frz_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(frz_q));
    // R12
    stall_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFF_DBG) |=> (stall == $past(wdata[DB_STALL])));
endmodule

// File: rtl/dfc_halt_route.sv
module dfc_halt_route
    import dfc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic src,
    input  logic enable,
    input  logic pulse_mode,
    output logic req
);
    halt_st_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= HALT_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HALT_IDLE: if (src)  state_d = HALT_HELD;
            HALT_HELD: if (!src) state_d = HALT_IDLE;
        endcase
    end

    always_comb begin
        req = 1'b0;
        if (enable) begin
            if (pulse_mode) req = src && (state_q == HALT_IDLE);
            else            req = src;
        end
    end

    // R10
    pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_mode && req && src) |=> !(pulse_mode && req));
    // R10
    pulse_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_mode && enable && $rose(src)) |-> req);
endmodule

// File: rtl/dfc_freeze_merge.sv
module dfc_freeze_merge
    import dfc_pkg::*;
(
    input  logic [N_FRZ-1:0] sw_frz,
    input  logic             sys_halt,
    input  logic             aux_halt,
    input  logic             sys_fen,
    input  logic             aux_fen,
    input  logic             nmi_mode,
    output logic [N_FRZ-1:0] frz
);
    logic sys_all, aux_all;
    assign sys_all = sys_halt && sys_fen;
    assign aux_all = aux_halt && aux_fen;

    for (genvar i = 0; i < N_FRZ; i++) begin : g_tgt
        if (i == WDOG_BIT) begin : g_wdog
            assign frz[i] = sys_halt || (!nmi_mode && (sw_frz[i] || aux_all));
        end else begin : g_plain
            assign frz[i] = sw_frz[i] || sys_all || aux_all;
        end
    end
endmodule

// File: rtl/dbg_freeze_ctrl.sv
module dbg_freeze_ctrl
    import dfc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              sys_dbg_halt,
    input  logic              aux_dbg_halt,
    input  logic              nmi_rst_mode,
    output logic [N_FRZ-1:0]  frz,
    output logic              halt_req_aux,
    output logic              halt_req_main,
    output logic              core_stall,
    output logic              cal_flag,
    output logic              bridge_skip
);
    logic [N_FRZ-1:0] sw_frz;
    logic sys_fen, aux_fen, route_m2a, route_a2m, pulse_mode;

    dfc_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .sys_halt(sys_dbg_halt), .aux_halt(aux_dbg_halt),
        .sw_frz(sw_frz), .sys_fen(sys_fen), .aux_fen(aux_fen),
        .route_m2a(route_m2a), .route_a2m(route_a2m), .stall(core_stall),
        .pulse_mode(pulse_mode), .cal(cal_flag), .byp(bridge_skip), .rdata(rdata)
    );

    dfc_freeze_merge u_merge (
        .sw_frz(sw_frz), .sys_halt(sys_dbg_halt), .aux_halt(aux_dbg_halt),
        .sys_fen(sys_fen), .aux_fen(aux_fen), .nmi_mode(nmi_rst_mode), .frz(frz)
    );

    dfc_halt_route u_m2a (
        .clk(clk), .rst_n(rst_n), .src(sys_dbg_halt), .enable(route_m2a),
        .pulse_mode(pulse_mode), .req(halt_req_aux)
    );

    dfc_halt_route u_a2m (
        .clk(clk), .rst_n(rst_n), .src(aux_dbg_halt), .enable(route_a2m),
        .pulse_mode(pulse_mode), .req(halt_req_main)
    );

    // R7
    wdog_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sys_dbg_halt |-> frz[WDOG_BIT]);
    // R6
    all_frz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_dbg_halt && rdata[DB_SYS_FEN] && addr == OFF_DBG) |-> (&frz));
    // R9
    route_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !route_m2a |-> !halt_req_aux);
endmodule

// File: tb/tb_dbg_freeze_ctrl.sv
module tb_dbg_freeze_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        sys_h = 1'b0, aux_h = 1'b0, nmi = 1'b0;
    logic [31:0] rdata;
    logic [10:0] frz;
    logic        req_aux, req_main, stall, calf, byp;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    logic [10:0] m_sw;
    logic m_sfen, m_afen, m_m2a, m_a2m, m_stall, m_pulse, m_cal, m_byp, m_ps, m_pa;

    always #4 clk = ~clk;

    dbg_freeze_ctrl dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .sys_dbg_halt(sys_h), .aux_dbg_halt(aux_h),
        .nmi_rst_mode(nmi), .frz(frz), .halt_req_aux(req_aux),
        .halt_req_main(req_main), .core_stall(stall), .cal_flag(calf),
        .bridge_skip(byp)
    );

    task automatic ck(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", cur_req, what, act, exp);
        end
    endtask

    task automatic model_step();
        if (!rst_n) begin
            m_sw = '0; m_sfen = 1; m_afen = 0; m_m2a = 0; m_a2m = 0;
            m_stall = 0; m_pulse = 0; m_cal = 0; m_byp = 0; m_ps = 0; m_pa = 0;
        end else begin
            if (wr_en) begin
                if (addr == 5'h00) m_sw = m_sw | wdata[10:0];
                else if (addr == 5'h04) m_sw = m_sw & ~wdata[10:0];
                else if (addr == 5'h08) begin
                    m_sfen = wdata[0]; m_afen = wdata[1]; m_m2a = wdata[2];
                    m_a2m = wdata[3]; m_stall = wdata[6]; m_pulse = wdata[7];
                end
                else if (addr == 5'h0C) m_cal = wdata[0];
                else if (addr == 5'h10) m_byp = wdata[0];
            end
            m_ps = sys_h;
            m_pa = aux_h;
        end
    endtask

    task automatic compare();
        logic [31:0] e_rd;
        logic [10:0] e_frz;
        logic e_ra, e_rm;
        e_rd = '0;
        if (addr == 5'h00 || addr == 5'h04) e_rd[10:0] = m_sw;
        else if (addr == 5'h08)
            e_rd = {24'd0, m_pulse, m_stall, aux_h, sys_h, m_a2m, m_m2a, m_afen, m_sfen};
        else if (addr == 5'h0C) e_rd[0] = m_cal;
        else if (addr == 5'h10) e_rd[0] = m_byp;
        for (int i = 0; i < 11; i++) begin
            if (i == 3)
                e_frz[i] = sys_h | (!nmi & (m_sw[i] | (aux_h & m_afen)));
            else
                e_frz[i] = m_sw[i] | (sys_h & m_sfen) | (aux_h & m_afen);
        end
        e_ra = m_m2a & (m_pulse ? (sys_h & !m_ps) : sys_h);
        e_rm = m_a2m & (m_pulse ? (aux_h & !m_pa) : aux_h);
        ck("rdata", rdata, e_rd);
        ck("frz", {21'd0, frz}, {21'd0, e_frz});
        ck("halt_req_aux", {31'd0, req_aux}, {31'd0, e_ra});
        ck("halt_req_main", {31'd0, req_main}, {31'd0, e_rm});
        ck("core_stall", {31'd0, stall}, {31'd0, m_stall});
        ck("cal_flag", {31'd0, calf}, {31'd0, m_cal});
        ck("bridge_skip", {31'd0, byp}, {31'd0, m_byp});
    endtask

    task automatic cyc();
        @(posedge clk);
        #1 model_step();
        #1 compare();
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        wr_en = 1; addr = a; wdata = d;
        cyc();
        wr_en = 0;
        cyc();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1 reset state
        cur_req = "R1";
        cyc(); cyc();
        rst_n = 1;
        addr = 5'h08; cyc(); cyc();
        // R2 set register, zeros ignored
        cur_req = "R2";
        wr(5'h00, 32'h0000_00A5);
        wr(5'h00, 32'h0000_0000);
        addr = 5'h04; cyc();
        wr(5'h00, 32'hFFFF_F800);
        // R3 clear register
        cur_req = "R3";
        wr(5'h04, 32'h0000_0005);
        wr(5'h04, 32'h0000_0000);
        addr = 5'h00; cyc();
        // R4 per-target order
        cur_req = "R4";
        for (int i = 0; i < 11; i++) begin
            wr(5'h00, 32'(1) << i);
            wr(5'h04, 32'h7FF);
        end
        // R5 watchdog software freeze blocked by NMI mode
        cur_req = "R5";
        wr(5'h00, 32'h0000_0008);
        nmi = 1; cyc();
        nmi = 0; cyc();
        wr(5'h04, 32'h7FF);
        // R6 main halt with and without enable
        cur_req = "R6";
        wr(5'h00, 32'h0000_0020);
        sys_h = 1; cyc(); cyc();
        wr(5'h08, 32'h0);
        // R7 watchdog always frozen on main halt
        cur_req = "R7";
        nmi = 1; cyc();
        wr(5'h08, 32'h1); cyc();
        sys_h = 0; cyc();
        nmi = 0;
        // R8 auxiliary halt
        cur_req = "R8";
        wr(5'h08, 32'h2);
        aux_h = 1; cyc();
        nmi = 1; cyc();
        nmi = 0; cyc();
        aux_h = 0; cyc();
        wr(5'h08, 32'h0);
        aux_h = 1; cyc(); aux_h = 0; cyc();
        wr(5'h04, 32'h7FF);
        // R9 level routing
        cur_req = "R9";
        wr(5'h08, 32'h0C);
        sys_h = 1; cyc(); cyc();
        aux_h = 1; cyc();
        sys_h = 0; cyc();
        aux_h = 0; cyc();
        wr(5'h08, 32'h04);
        aux_h = 1; sys_h = 1; cyc(); aux_h = 0; sys_h = 0; cyc();
        // R10 pulse routing
        cur_req = "R10";
        wr(5'h08, 32'h8C);
        sys_h = 1; cyc(); cyc(); cyc();
        sys_h = 0; cyc();
        sys_h = 1; cyc(); sys_h = 0; cyc();
        aux_h = 1; cyc(); cyc();
        wr(5'h08, 32'h08); cyc();
        wr(5'h08, 32'h88); cyc();
        aux_h = 0; cyc();
        aux_h = 1; cyc(); aux_h = 0; cyc();
        // R11 halt status read-only
        cur_req = "R11";
        wr(5'h08, 32'h31);
        addr = 5'h08; sys_h = 1; cyc();
        aux_h = 1; cyc();
        sys_h = 0; cyc(); aux_h = 0; cyc();
        // R12 core stall
        cur_req = "R12";
        wr(5'h08, 32'h41);
        cyc();
        wr(5'h08, 32'h01);
        // R13 flags and unmapped offsets
        cur_req = "R13";
        wr(5'h0C, 32'hFFFF_FFFF);
        wr(5'h10, 32'hFFFF_FFFF);
        addr = 5'h0C; cyc();
        wr(5'h14, 32'hFFFF_FFFF);
        addr = 5'h14; cyc();
        wr(5'h0C, 32'h0);
        wr(5'h10, 32'h0);
        addr = 5'h00; cyc();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule